// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier

This block forms the product of two 16-bit integers in one clock. Either operand may be read as two's-complement or as unsigned, and each side's choice is independent. This gives four sign combinations. A byte mode multiplies only the low eight bits of each operand. The whole computation uses a single 17-by-17 signed product array. Before the array, each operand gets one extra top bit. That bit copies the operand's top bit when the operand is signed, and is 0 when it is unsigned. After this widening, one signed multiply is exact for every combination.

A caller presents both operands, a two-bit sign mode and the byte/word choice, and raises the valid strobe for one cycle. On the next clock edge, the 32-bit result and a one-cycle result-valid pulse appear on registered outputs. Requests may be issued on every cycle. The output register holds its last result while no request is made.

Top module: `mixmul_top`

## Requirements
- R1: With `sign_mode` = 2'b00, both operands are unsigned and `prod` is their exact 32-bit product.
- R2: With `sign_mode` = 2'b11, both operands are two's-complement and `prod` is the exact product in 32-bit two's-complement.
- R3: `sign_mode` bit 1 marks `op_a` as signed and bit 0 marks `op_b` as signed. Mode 2'b01 (A unsigned, B signed) and mode 2'b10 (A signed, B unsigned) give the exact mixed-sign product.
- R4: With `byte_sel` = 1, only bits [7:0] of each operand are used and bits [15:8] have no effect. The product of the two bytes, under the same sign rules, appears sign- or zero-extended across all 32 bits of `prod`.
- R5: A request with `in_valid` high at clock edge N gives its result on `prod` and a high `prod_valid` after edge N. `prod_valid` is low after any edge where `in_valid` was low.
- R6: While `in_valid` is low, `prod` keeps its previous value whatever the operand inputs do.
- R7: Synchronous active-high `rst` clears `prod` to 0 and `prod_valid` to 0, and takes precedence over an `in_valid` that is high in the same cycle.
- R8: Requests on consecutive cycles each produce their own result, one per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| sign_mode | input | 2 | Bit 1: A signed; bit 0: B signed |
| byte_sel | input | 1 | 1 selects 8x8 on the low bytes |
| prod | output | 32 | Registered product |
| prod_valid | output | 1 | One-cycle pulse marking a new product |

## Verification
Two events can land on the same clock edge. One is reset; the other is capture of a new request, or the result of one request being shown while the next is taken. The bench asserts reset while `in_valid` is high and checks that no result pulse and no non-zero product follow. It also streams requests back to back across all modes and byte/word settings, with corner operands 0, 0xFFFF, 0x8000, 0x7FFF and 1 plus random values. Each streamed result is matched in order against a behavioural product computed on wide integers.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  typedef enum logic [1:0] {
    MODE_UU = 2'b00,
    MODE_US = 2'b01,
    MODE_SU = 2'b10,
    MODE_SS = 2'b11
  } mul_mode_e;

  function automatic logic a_is_signed(input mul_mode_e m);
    return (m == MODE_SU) || (m == MODE_SS);
  endfunction

  function automatic logic b_is_signed(input mul_mode_e m);
    return (m == MODE_US) || (m == MODE_SS);
  endfunction
endpackage

// File: rtl/mixmul_extend.sv
module mixmul_extend #(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic [OP_W-1:0] opnd,
  input  logic            is_signed,
  input  logic            byte_sel,
  output logic [OP_W:0]   ext
);
  localparam int PAD_W = OP_W - BYTE_W;

  logic          fill_word;
  logic          fill_byte;
  logic [OP_W:0] word_ext;
  logic [OP_W:0] byte_ext;

  assign fill_word = is_signed & opnd[OP_W-1];
  assign fill_byte = is_signed & opnd[BYTE_W-1];
  assign word_ext  = {fill_word, opnd};
  assign byte_ext  = {{(PAD_W+1){fill_byte}}, opnd[BYTE_W-1:0]};

  always_comb begin
    if (byte_sel) ext = byte_ext;
    else          ext = word_ext;
  end
endmodule

// File: rtl/mixmul_array.sv
module mixmul_array #(
  parameter int EXT_W = 17
) (
  input  logic [EXT_W-1:0]   a,
  input  logic [EXT_W-1:0]   b,
  output logic [2*EXT_W-1:0] full
);
  localparam int PW = 2 * EXT_W;

  logic [PW-1:0] a_wide;
  logic [PW-1:0] rows [EXT_W];

  assign a_wide = {{(PW-EXT_W){a[EXT_W-1]}}, a};

  for (genvar i = 0; i < EXT_W; i++) begin : g_row
    if (i == EXT_W - 1) begin : g_neg
      assign rows[i] = b[i] ? (PW'(0) - (a_wide << i)) : '0;
    end else begin : g_pos
      assign rows[i] = b[i] ? (a_wide << i) : '0;
    end
  end

  always_comb begin
    full = '0;
    for (int i = 0; i < EXT_W; i++) full = full + rows[i];
  end
endmodule

// File: rtl/mixmul_top.sv
module mixmul_top #(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [1:0]        sign_mode,
  input  logic              byte_sel,
  output logic [2*OP_W-1:0] prod,
  output logic              prod_valid
);
  import mixmul_pkg::*;

  localparam int EXT_W = OP_W + 1;
  localparam int PW    = 2 * EXT_W;
  localparam int OUT_W = 2 * OP_W;

  mul_mode_e        mode;
  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [PW-1:0]    full;

  assign mode = mul_mode_e'(sign_mode);

  mixmul_extend #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_ext_a (
    .opnd(op_a), .is_signed(a_is_signed(mode)), .byte_sel(byte_sel), .ext(a_ext)
  );

  mixmul_extend #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_ext_b (
    .opnd(op_b), .is_signed(b_is_signed(mode)), .byte_sel(byte_sel), .ext(b_ext)
  );

  mixmul_array #(.EXT_W(EXT_W)) u_array (
    .a(a_ext), .b(b_ext), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod       <= '0;
      prod_valid <= 1'b0;
    end else begin
      prod_valid <= in_valid;
      if (in_valid) prod <= full[OUT_W-1:0];
    end
  end

  // R5: a request is answered after exactly one edge
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !prod_valid);
  // R6: idle cycles leave the result untouched
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod));
  // R4: unsigned byte products never reach the upper half
  p_byte_unsigned_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_sel && sign_mode == 2'b00) |=> (prod[OUT_W-1:OUT_W/2] == '0));
  // R1: a zero operand forces a zero product
  p_zero_operand_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a == '0) |=> (prod == '0));
  // R2: the widened operands keep every product inside 33 signed bits
  p_headroom_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (full[PW-1] == full[PW-2]));
endmodule

// File: tb/sim_mixmul_top.sv
module sim_mixmul_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [1:0]  sign_mode = '0;
  logic        byte_sel = 1'b0;
  logic [31:0] prod;
  logic        prod_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  mixmul_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sign_mode(sign_mode), .byte_sel(byte_sel), .prod(prod), .prod_valid(prod_valid)
  );

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                          input logic [1:0] m, input logic bs);
    longint av, bv, p;
    if (bs) begin
      av = longint'(a[7:0]); if (m[1] && a[7]) av -= 256;
      bv = longint'(b[7:0]); if (m[0] && b[7]) bv -= 256;
    end else begin
      av = longint'(a); if (m[1] && a[15]) av -= 65536;
      bv = longint'(b); if (m[0] && b[15]) bv -= 65536;
    end
    p = av * bv;
    return p[31:0];
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic bs);
    if (bs) return "R4";
    case (m)
      2'b00:   return "R1";
      2'b11:   return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b,
                      input logic [1:0] m, input logic bs);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; sign_mode = m; byte_sel = bs; in_valid = 1'b1;
    it.exp = ref_mul(a, b, m, bs);
    it.tag = tag_of(m, bs);
    sb.push_back(it);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: R8 ordering, R5 pulse presence
  always @(negedge clk) begin
    if (!rst && prod_valid) begin
      if (sb.size() == 0) begin
        check("R5 unexpected pulse", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, "/R8"}, prod, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corners [5];
    logic [31:0] held;
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h7FFF; corners[4] = 16'h0001;

    repeat (3) @(negedge clk);
    check("R7 reset prod", prod, 32'd0);
    check("R7 reset valid", {31'd0, prod_valid}, 32'd0);
    rst = 1'b0;

    // corners, back to back (R1 R2 R3 R4 R8)
    for (int bs = 0; bs < 2; bs++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            send(corners[i], corners[j], 2'(m), 1'(bs));
    go_idle();

    // R5: single request, then idle pulse must drop
    send(16'h1234, 16'h00FF, 2'b00, 1'b0);
    go_idle();
    @(negedge clk);
    check("R5 pulse width", {31'd0, prod_valid}, 32'd0);

    // R6: operands move while idle; output holds
    held = prod;
    op_a = 16'hDEAD; op_b = 16'hBEEF; sign_mode = 2'b11;
    repeat (2) @(negedge clk);
    check("R6 hold prod", prod, held);
    check("R6 hold valid", {31'd0, prod_valid}, 32'd0);

    // R4: upper bytes ignored in byte mode
    send(16'hAB80, 16'h7F03, 2'b11, 1'b1);
    send(16'h0080, 16'h0003, 2'b11, 1'b1);
    go_idle();

    // random streams with gaps
    for (int k = 0; k < 600; k++) begin
      send(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
      if (($urandom % 5) == 0) go_idle();
    end
    go_idle();
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 32'(sb.size()), 32'd0);

    // R7: reset wins over a same-cycle request
    op_a = 16'h0003; op_b = 16'h0005; sign_mode = 2'b00; byte_sel = 1'b0;
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R7 reset over valid prod", prod, 32'd0);
    check("R7 reset over valid pulse", {31'd0, prod_valid}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R7 no late pulse", {31'd0, prod_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule